// File: doc/BRIEF.md
# FP64 Round-to-Integral Unit

This unit takes one double-precision operand and returns the nearest integral value under a selectable rounding mode. The result stays in double-precision format. It occupies the low 64 bits of a 128-bit result, and the high 64 bits are taken from a separate 128-bit operand. An 8-bit control byte does three things:

- It picks a per-operation rounding mode.
- It can defer to a rounding-mode field supplied from an external global control register.
- It can silence the inexact flag for that one operation.

A flush-denormals input forces denormal operands to a signed zero before rounding. The unit reports invalid and inexact status flags. It also drives a denormal flag, which this operation never raises. A wide-destination mode input produces a marker that tells the register file whether destination bits above 127 must be cleared or kept.

The unit has one register stage between input and output. A small state machine tracks whether that stage holds a result. It has two states:

- `ST_IDLE`: no result is held.
- `ST_VALID`: a result is presented.

It has three named transitions:

- ACCEPT: `ST_IDLE` to `ST_VALID` when `in_valid` is 1.
- STREAM: `ST_VALID` to `ST_VALID` when `in_valid` is 1.
- DRAIN: `ST_VALID` to `ST_IDLE` when `in_valid` is 0.

While `ST_IDLE` sees no `in_valid`, the machine stays in `ST_IDLE`.

Top module: `fp64_round_int`

## Requirements
- R1: With control bit 2 at 0, control bits 1:0 select the mode: 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R2: With control bit 2 at 1, the mode comes from `glob_rc` under the same encoding, and control bits 1:0 have no effect on the result.
- R3: With control bit 3 at 0, `flag_inexact` is 1 exactly when the result differs from the operand. With bit 3 at 1, `flag_inexact` stays 0 while the value is still rounded.
- R4: A signaling NaN (exponent all ones, fraction nonzero, fraction bit 51 at 0) returns the same sign and payload with fraction bit 51 set, and raises `flag_invalid`. A quiet NaN passes through unchanged. No other operand raises `flag_invalid`.
- R5: With `daz` at 1, a denormal operand becomes a zero of the same sign before rounding, so it returns that zero with no flags. With `daz` at 0, it is rounded like any value below one.
- R6: `flag_denorm` is 0 for every operation.
- R7: `result[127:64]` equals `src_upper[127:64]` of the same operation.
- R8: `upper_clr` equals the `wide_mode` of the same operation: 1 means clear bits above 127, 0 means keep them.
- R9: Infinities, zeros and operands with unbiased exponent of at least 52 return unchanged with no flags.
- R10: A result of zero carries the operand's sign, for example -0.3 rounded toward plus infinity gives -0.0.
- R11: `out_valid` is 1 in the cycle after a cycle with `in_valid` at 1 and 0 otherwise. Outputs hold while `in_valid` is 0, and all outputs are 0 after reset.
- R12: A carry out of the integer mantissa raises the exponent by one with a zero fraction, for example 2^52-0.5 rounded up gives 2^52. A value below one rounds to a signed 1.0 or a signed zero according to the mode, with an exact half going to zero under nearest-even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation presented this cycle |
| ctrl_imm | input | 8 | Control byte: bit 3 silences inexact, bit 2 selects global mode, bits 1:0 local mode |
| glob_rc | input | 2 | Global rounding-mode field |
| daz | input | 1 | Flush denormal operands to zero |
| wide_mode | input | 1 | Wide destination encoding, upper bits cleared |
| src_upper | input | 128 | Operand whose bits 127:64 form the result's upper lane |
| src_val | input | 64 | Double-precision value to round |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Rounded value in 63:0, merged upper lane in 127:64 |
| flag_invalid | output | 1 | Invalid status (signaling NaN input) |
| flag_inexact | output | 1 | Inexact status |
| flag_denorm | output | 1 | Denormal status, never raised |
| upper_clr | output | 1 | Destination bits above 127 to be zeroed |

## Verification
On every cycle the assertions check a set of input-to-output relations one cycle later:

- the upper-lane merge and the wide-destination marker;
- the one-cycle valid relation and the holding of outputs when idle;
- inexact suppression by control bit 3;
- invalid appearing only for signaling NaNs;
- the flushed-denormal result.

The numeric correctness of rounding can only be shown by the bench's directed scenarios, each compared against a model built on real arithmetic. This covers the four modes, selection between the local and global mode, tie handling, carries into the exponent, signed zeros and NaN quieting.

// File: rtl/fpri_pkg.sv
package fpri_pkg;

    localparam int DEF_EXP_W  = 11;
    localparam int DEF_FRAC_W = 52;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_t;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_FLUSH,
        CL_TINY,
        CL_FRAC,
        CL_INTEGRAL,
        CL_INF,
        CL_QNAN,
        CL_SNAN
    } fclass_t;

    typedef enum logic {
        ST_IDLE,
        ST_VALID
    } state_t;

endpackage

// File: rtl/fpri_mode_sel.sv
module fpri_mode_sel
    import fpri_pkg::*;
(
    input  logic [7:0] ctrl_imm,
    input  logic [1:0] glob_rc,
    output rmode_t     mode,
    output logic       quiet_inexact
);
    logic unused_imm_hi;
    assign unused_imm_hi = ^ctrl_imm[7:4];

    always_comb begin
        if (ctrl_imm[2]) begin
            mode = rmode_t'(glob_rc);
        end else begin
            mode = rmode_t'(ctrl_imm[1:0]);
        end
        quiet_inexact = ctrl_imm[3];
    end
endmodule

// File: rtl/fpri_classify.sv
module fpri_classify
    import fpri_pkg::*;
#(
    parameter int EXP_W  = DEF_EXP_W,
    parameter int FRAC_W = DEF_FRAC_W,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] val,
    input  logic         daz,
    output fclass_t      cls
);
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int INT_LIM = BIAS + FRAC_W;

    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;

    assign ex = val[W-2:FRAC_W];
    assign fr = val[FRAC_W-1:0];

    always_comb begin
        if (&ex) begin
            if (fr == '0)          cls = CL_INF;
            else if (fr[FRAC_W-1]) cls = CL_QNAN;
            else                   cls = CL_SNAN;
        end else if (ex == '0) begin
            if (fr == '0)          cls = CL_ZERO;
            else if (daz)          cls = CL_FLUSH;
            else                   cls = CL_TINY;
        end else if (ex < EXP_W'(BIAS)) begin
            cls = CL_TINY;
        end else if (ex < EXP_W'(INT_LIM)) begin
            cls = CL_FRAC;
        end else begin
            cls = CL_INTEGRAL;
        end
    end
endmodule

// File: rtl/fpri_core.sv
module fpri_core
    import fpri_pkg::*;
#(
    parameter int EXP_W  = DEF_EXP_W,
    parameter int FRAC_W = DEF_FRAC_W,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] val,
    input  fclass_t      cls,
    input  rmode_t       mode,
    input  logic         quiet_inexact,
    output logic [W-1:0] res,
    output logic         inv,
    output logic         inx
);
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int INT_LIM = BIAS + FRAC_W;
    localparam int MW      = FRAC_W + 2;
    localparam int SH_W    = $clog2(FRAC_W + 1) + 1;

    logic              sgn;
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;
    logic [EXP_W:0]    nf_full;
    logic [SH_W-1:0]   nf;
    logic [MW-1:0]     mant, one, mask, half, fpart, tpart, sum;
    logic              lsb_int, up_frac, up_tiny, inx_raw;

    assign sgn = val[W-1];
    assign ex  = val[W-2:FRAC_W];
    assign fr  = val[FRAC_W-1:0];

    // count of fraction bits below the binary point for in-range operands
    assign nf_full = (EXP_W+1)'(INT_LIM) - {1'b0, ex};
    assign nf      = nf_full[SH_W-1:0];
    assign mant    = {1'b0, 1'b1, fr};
    assign one     = MW'(1) << nf;
    assign mask    = one - MW'(1);
    assign half    = one >> 1;
    assign fpart   = mant & mask;
    assign tpart   = mant & ~mask;
    assign lsb_int = |(mant & one);

    always_comb begin
        unique case (mode)
            RM_NEAR: up_frac = (fpart > half) || ((fpart == half) && lsb_int);
            RM_DOWN: up_frac = sgn && (fpart != '0);
            RM_UP:   up_frac = !sgn && (fpart != '0);
            default: up_frac = 1'b0;
        endcase
        unique case (mode)
            RM_NEAR: up_tiny = (ex == EXP_W'(BIAS - 1)) && (fr != '0);
            RM_DOWN: up_tiny = sgn;
            RM_UP:   up_tiny = !sgn;
            default: up_tiny = 1'b0;
        endcase
    end

    assign sum = tpart + (up_frac ? one : '0);

    always_comb begin
        res     = val;
        inv     = 1'b0;
        inx_raw = 1'b0;
        unique case (cls)
            CL_SNAN: begin
                res[FRAC_W-1] = 1'b1;
                inv           = 1'b1;
            end
            CL_FLUSH: begin
                res = {sgn, {(W-1){1'b0}}};
            end
            CL_TINY: begin
                inx_raw = 1'b1;
                if (up_tiny) res = {sgn, EXP_W'(BIAS), {FRAC_W{1'b0}}};
                else         res = {sgn, {(W-1){1'b0}}};
            end
            CL_FRAC: begin
                inx_raw = (fpart != '0);
                if (sum[MW-1]) res = {sgn, ex + EXP_W'(1), {FRAC_W{1'b0}}};
                else           res = {sgn, ex, sum[FRAC_W-1:0]};
            end
            default: begin
                res = val;
            end
        endcase
        inx = inx_raw && !quiet_inexact;
    end
endmodule

// File: rtl/fp64_round_int.sv
module fp64_round_int
    import fpri_pkg::*;
#(
    parameter int EXP_W  = DEF_EXP_W,
    parameter int FRAC_W = DEF_FRAC_W,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [7:0]     ctrl_imm,
    input  logic [1:0]     glob_rc,
    input  logic           daz,
    input  logic           wide_mode,
    input  logic [2*W-1:0] src_upper,
    input  logic [W-1:0]   src_val,
    output logic           out_valid,
    output logic [2*W-1:0] result,
    output logic           flag_invalid,
    output logic           flag_inexact,
    output logic           flag_denorm,
    output logic           upper_clr
);
    state_t   state, nxt;
    rmode_t   mode;
    logic     quiet_inexact;
    fclass_t  cls;
    logic [W-1:0] rnd;
    logic     c_inv, c_inx;
    logic     unused_upper_lo;

    assign unused_upper_lo = ^src_upper[W-1:0];

    fpri_mode_sel u_mode (
        .ctrl_imm      (ctrl_imm),
        .glob_rc       (glob_rc),
        .mode          (mode),
        .quiet_inexact (quiet_inexact)
    );

    fpri_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
        .val (src_val),
        .daz (daz),
        .cls (cls)
    );

    fpri_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_core (
        .val           (src_val),
        .cls           (cls),
        .mode          (mode),
        .quiet_inexact (quiet_inexact),
        .res           (rnd),
        .inv           (c_inv),
        .inx           (c_inx)
    );

    // transitions: ACCEPT (idle->valid), STREAM (valid->valid), DRAIN (valid->idle)
    always_comb begin
        unique case (state)
            ST_IDLE:  nxt = in_valid ? ST_VALID : ST_IDLE;
            ST_VALID: nxt = in_valid ? ST_VALID : ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
            upper_clr    <= 1'b0;
        end else if (in_valid) begin
            result       <= {src_upper[2*W-1:W], rnd};
            flag_invalid <= c_inv;
            flag_inexact <= c_inx;
            upper_clr    <= wide_mode;
        end
    end

    assign out_valid   = (state == ST_VALID);
    assign flag_denorm = 1'b0;
endmodule

// File: rtl/fpri_chk.sv
module fpri_chk #(
    parameter int W = 64
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [7:0]     ctrl_imm,
    input logic           daz,
    input logic           wide_mode,
    input logic [2*W-1:0] src_upper,
    input logic [W-1:0]   src_val,
    input logic           out_valid,
    input logic [2*W-1:0] result,
    input logic           flag_invalid,
    input logic           flag_inexact,
    input logic           upper_clr
);
    localparam int FRAC_W = 52;
    localparam int EXP_W  = W - 1 - FRAC_W;

    logic in_snan, in_denorm;
    assign in_snan   = (&src_val[W-2:FRAC_W]) && (src_val[FRAC_W-1:0] != '0) && !src_val[FRAC_W-1];
    assign in_denorm = (src_val[W-2:FRAC_W] == '0) && (src_val[FRAC_W-1:0] != '0);

    p_upper_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> result[2*W-1:W] == $past(src_upper[2*W-1:W]));

    p_wide_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> upper_clr == $past(wide_mode));

    p_valid_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(flag_inexact) && $stable(flag_invalid));

    p_quiet_inexact_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctrl_imm[3]) |=> !flag_inexact);

    p_invalid_only_snan_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_snan) |=> !flag_invalid);

    p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && daz && in_denorm) |=> (result[W-2:0] == '0) && !flag_inexact);

    logic unused_exp;
    assign unused_exp = (EXP_W == 0);
endmodule

bind fp64_round_int fpri_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .ctrl_imm     (ctrl_imm),
    .daz          (daz),
    .wide_mode    (wide_mode),
    .src_upper    (src_upper),
    .src_val      (src_val),
    .out_valid    (out_valid),
    .result       (result),
    .flag_invalid (flag_invalid),
    .flag_inexact (flag_inexact),
    .upper_clr    (upper_clr)
);

// File: tb/fp64_round_int_tb.sv
module fp64_round_int_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [7:0]   ctrl_imm = '0;
    logic [1:0]   glob_rc = '0;
    logic         daz = 1'b0;
    logic         wide_mode = 1'b0;
    logic [127:0] src_upper = '0;
    logic [63:0]  src_val = '0;
    logic         out_valid;
    logic [127:0] result;
    logic         flag_invalid, flag_inexact, flag_denorm, upper_clr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fp64_round_int u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ctrl_imm(ctrl_imm),
        .glob_rc(glob_rc), .daz(daz), .wide_mode(wide_mode),
        .src_upper(src_upper), .src_val(src_val), .out_valid(out_valid),
        .result(result), .flag_invalid(flag_invalid), .flag_inexact(flag_inexact),
        .flag_denorm(flag_denorm), .upper_clr(upper_clr)
    );

    task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // reference: round via real arithmetic, keep operand sign on zero
    function automatic logic [63:0] model(input logic [63:0] x, input logic [1:0] m, input logic dz);
        real v, fl, r;
        if (dz && x[62:52] == '0) return {x[63], 63'b0};
        v  = $bitstoreal(x);
        fl = $floor(v);
        case (m)
            2'b00: begin
                if (v - fl > 0.5) r = fl + 1.0;
                else if (v - fl < 0.5) r = fl;
                else r = (fl - 2.0 * $floor(fl / 2.0) == 0.0) ? fl : fl + 1.0;
            end
            2'b01: r = fl;
            2'b10: r = $ceil(v);
            default: r = (v < 0.0) ? $ceil(v) : fl;
        endcase
        if (r == 0.0) return {x[63], 63'b0};
        return $realtobits(r);
    endfunction

    task automatic op(input logic [63:0] x, input logic [7:0] imm, input logic [1:0] grc,
                      input logic dz, input logic wide, input logic [63:0] hi);
        @(negedge clk);
        src_val = x; ctrl_imm = imm; glob_rc = grc; daz = dz; wide_mode = wide;
        src_upper = {hi, ~x};
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // numeric op checked against the model; also covers R6, R7, R8
    task automatic num(input string req, input real v, input logic [7:0] imm,
                       input logic [1:0] grc, input logic dz);
        logic [63:0] x, e;
        logic [1:0]  m;
        x = $realtobits(v);
        m = imm[2] ? grc : imm[1:0];
        op(x, imm, grc, dz, 1'b0, 64'hA5A5_0000_1234_5678);
        e = model(x, m, dz);
        chk(req, {64'h0, result[63:0]}, {64'h0, e});
        chk({req, " inexact R3"}, {127'h0, flag_inexact}, {127'h0, (e != x) && !imm[3]});
        chk("R7 upper lane", {64'h0, result[127:64]}, {64'h0, 64'hA5A5_0000_1234_5678});
        chk("R6 denorm flag", {127'h0, flag_denorm}, 128'h0);
        chk("R4 invalid only on snan", {127'h0, flag_invalid}, 128'h0);
    endtask

    task automatic t_reset;
        chk("R11 reset out_valid", {127'h0, out_valid}, 128'h0);
        chk("R11 reset result", result, 128'h0);
        chk("R11 reset flags", {124'h0, flag_invalid, flag_inexact, flag_denorm, upper_clr}, 128'h0);
    endtask

    task automatic t_local_modes;
        for (int m = 0; m < 4; m++) begin
            num("R1 mode 2.5", 2.5, 8'(m), 2'b00, 1'b0);
            num("R1 mode -2.5", -2.5, 8'(m), 2'b00, 1'b0);
            num("R1 mode 3.7", 3.7, 8'(m), 2'b00, 1'b0);
            num("R1 mode -7.25", -7.25, 8'(m), 2'b00, 1'b0);
        end
        num("R1 nearest 3.5 tie up", 3.5, 8'h00, 2'b00, 1'b0);
    endtask

    task automatic t_global_mode;
        num("R2 global up, local down", 1.2, 8'h05, 2'b10, 1'b0);
        num("R2 global zero, local up", -1.8, 8'h06, 2'b11, 1'b0);
        num("R2 global down", 1.9, 8'h04, 2'b01, 1'b0);
        num("R2 local again ignores glob", 1.2, 8'h01, 2'b10, 1'b0);
    endtask

    task automatic t_inexact;
        num("R3 suppressed", 5.6, 8'h08, 2'b00, 1'b0);
        num("R3 suppressed global", 5.6, 8'h0C, 2'b10, 1'b0);
        num("R3 exact no flag", 6.0, 8'h00, 2'b00, 1'b0);
    endtask

    task automatic t_nan;
        op(64'h7FF0_0000_0000_0001, 8'h00, 2'b00, 1'b0, 1'b0, 64'h1);
        chk("R4 snan quieted", {64'h0, result[63:0]}, {64'h0, 64'h7FF8_0000_0000_0001});
        chk("R4 snan invalid", {127'h0, flag_invalid}, 128'h1);
        op(64'hFFF4_0000_0000_00AB, 8'h08, 2'b00, 1'b0, 1'b0, 64'h1);
        chk("R4 neg snan quieted", {64'h0, result[63:0]}, {64'h0, 64'hFFFC_0000_0000_00AB});
        chk("R4 neg snan invalid", {127'h0, flag_invalid}, 128'h1);
        op(64'h7FF8_0000_0000_1234, 8'h02, 2'b00, 1'b0, 1'b0, 64'h1);
        chk("R4 qnan pass", {64'h0, result[63:0]}, {64'h0, 64'h7FF8_0000_0000_1234});
        chk("R4 qnan no flags", {126'h0, flag_invalid, flag_inexact}, 128'h0);
    endtask

    task automatic t_daz;
        op(64'h0000_0000_0000_0003, 8'h02, 2'b00, 1'b1, 1'b0, 64'h2);
        chk("R5 flushed pos", {64'h0, result[63:0]}, 128'h0);
        chk("R5 flushed no inexact", {127'h0, flag_inexact}, 128'h0);
        op(64'h800F_0000_0000_0000, 8'h01, 2'b00, 1'b1, 1'b0, 64'h2);
        chk("R5 flushed neg keeps sign", {64'h0, result[63:0]}, {64'h0, 64'h8000_0000_0000_0000});
        op(64'h0000_0000_0000_0003, 8'h02, 2'b00, 1'b0, 1'b0, 64'h2);
        chk("R5 no flush rounds up", {64'h0, result[63:0]}, {64'h0, 64'h3FF0_0000_0000_0000});
        chk("R5 no flush inexact", {127'h0, flag_inexact}, 128'h1);
        chk("R6 denorm flag on denormal", {127'h0, flag_denorm}, 128'h0);
    endtask

    task automatic t_pass;
        op(64'h4340_0000_0000_0001, 8'h02, 2'b00, 1'b0, 1'b0, 64'h3);
        chk("R9 large pass", {64'h0, result[63:0]}, {64'h0, 64'h4340_0000_0000_0001});
        chk("R9 large no flags", {126'h0, flag_invalid, flag_inexact}, 128'h0);
        op(64'hFFF0_0000_0000_0000, 8'h01, 2'b00, 1'b0, 1'b0, 64'h3);
        chk("R9 -inf pass", {64'h0, result[63:0]}, {64'h0, 64'hFFF0_0000_0000_0000});
        chk("R9 inf no flags", {126'h0, flag_invalid, flag_inexact}, 128'h0);
        op(64'h8000_0000_0000_0000, 8'h02, 2'b00, 1'b0, 1'b0, 64'h3);
        chk("R9 -0 pass", {64'h0, result[63:0]}, {64'h0, 64'h8000_0000_0000_0000});
    endtask

    task automatic t_signed_zero;
        op($realtobits(-0.3), 8'h02, 2'b00, 1'b0, 1'b0, 64'h4);
        chk("R10 -0.3 up gives -0", {64'h0, result[63:0]}, {64'h0, 64'h8000_0000_0000_0000});
        num("R10 0.3 down", 0.3, 8'h01, 2'b00, 1'b0);
        num("R10 -0.4 nearest", -0.4, 8'h00, 2'b00, 1'b0);
    endtask

    task automatic t_carry;
        op($realtobits(4503599627370495.5), 8'h02, 2'b00, 1'b0, 1'b0, 64'h5);
        chk("R12 carry to 2^52", {64'h0, result[63:0]}, {64'h0, 64'h4330_0000_0000_0000});
        op($realtobits(0.5), 8'h00, 2'b00, 1'b0, 1'b0, 64'h5);
        chk("R12 half ties to 0", {64'h0, result[63:0]}, 128'h0);
        op($realtobits(-0.75), 8'h00, 2'b00, 1'b0, 1'b0, 64'h5);
        chk("R12 -0.75 to -1", {64'h0, result[63:0]}, {64'h0, 64'hBFF0_0000_0000_0000});
        op($realtobits(1.5), 8'h00, 2'b00, 1'b0, 1'b0, 64'h5);
        chk("R12 1.5 to 2", {64'h0, result[63:0]}, {64'h0, 64'h4000_0000_0000_0000});
        num("R12 -0.1 down to -1", -0.1, 8'h01, 2'b00, 1'b0);
    endtask

    task automatic t_wide;
        op($realtobits(2.0), 8'h00, 2'b00, 1'b0, 1'b1, 64'h6);
        chk("R8 wide clears", {127'h0, upper_clr}, 128'h1);
        op($realtobits(2.0), 8'h00, 2'b00, 1'b0, 1'b0, 64'h6);
        chk("R8 narrow keeps", {127'h0, upper_clr}, 128'h0);
    endtask

    task automatic t_handshake;
        logic [127:0] held;
        @(negedge clk);
        src_val = $realtobits(9.9); ctrl_imm = 8'h00; src_upper = {64'h77, 64'h0};
        in_valid = 1'b1;
        chk("R11 not valid before edge", {127'h0, out_valid}, 128'h0);
        @(negedge clk);
        chk("R11 valid one cycle later", {127'h0, out_valid}, 128'h1);
        src_val = $realtobits(20.2);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R11 back-to-back result", {64'h0, result[63:0]}, {64'h0, $realtobits(20.0)});
        held = result;
        src_val = $realtobits(-99.9);
        @(negedge clk);
        chk("R11 drains", {127'h0, out_valid}, 128'h0);
        chk("R11 holds result when idle", result, held);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_local_modes();
        t_global_mode();
        t_inexact();
        t_nan();
        t_daz();
        t_pass();
        t_signed_zero();
        t_carry();
        t_wide();
        t_handshake();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule